// File: doc/BRIEF.md
# Adaptive-coefficient fifth-order delta-sigma modulator

This block converts oversampled PCM samples into a short signed code for a later PCM-to-PWM stage. It uses a fifth-order loop of five integrators. Each integrator has a gain, a weight on the fed-back quantized value, and, for the first four, a local resonator term taken from the next integrator. The code is the top bits of the last integrator.

The loop coefficients are not fixed. Two coefficient sets are stored. The quiet set gives strong in-band noise shaping and is used for small inputs. The loud set keeps the loop stable up to full scale and is used for large inputs. The block watches the magnitude of each sample against two thresholds with hysteresis. When the preferred set changes, it does not swap sets at once. It walks a step index across equal-sized intermediate sets. The index moves one step every few accepted samples, and it turns back from wherever it is if the preference flips during the walk. A busy flag shows that the walk has not reached the preferred end. Integrator states saturate and never wrap.

Top module: `adaptive_dsm`

## Requirements
- R1: After a synchronous active-low reset, all integrator states are zero, the step index is 0 (quiet set), the preferred set is the quiet set, out_valid is 0, out_code is 0 and ramp_busy is 0.
- R2: For each accepted sample (in_valid high), out_code takes the value floor(s5 / 2^(DATA_W-CODE_W)) of the fifth state as it was before that sample, and out_valid is high in exactly the next cycle. The fed-back value is v = out_code * 2^(DATA_W-CODE_W). Each state updates as s_k += floor(g_k*(u_k - floor(a_k*v/2^14))/2^14) - floor(b_k*s_{k+1}/2^14), where u_1 is the input and u_k = s_{k-1}, there is no resonator term for k=5, and all terms use the old values.
- R3: Each new state is clamped to the signed DATA_W range [-2^(DATA_W-1), 2^(DATA_W-1)-1] and never wraps.
- R4: A sample with magnitude above TH_HI makes the loud set preferred. A sample with magnitude below TH_LO makes the quiet set preferred. A magnitude between the two (inclusive) keeps the current preference.
- R5: The step index k runs from 0 (quiet) to N = 2^RAMP_LOG2 (loud). While k differs from the preferred end, it moves one step toward that end on every STEP_EVERY-th accepted sample. Coefficient i equals A_i + floor((B_i - A_i)*k/N). k never changes by more than 1 per sample.
- R6: If the preference flips during a walk, k turns around from its current value, and the sample count keeps running.
- R7: ramp_busy is high exactly when k is not at the end that matches the registered preference.
- R8: In cycles with in_valid low, no state, step index, preference or output code changes, and out_valid is 0.
- R9: At k=0 the coefficients equal the quiet set exactly. At k=N they equal the loud set exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The sample on in_data is accepted this cycle |
| in_data | input | DATA_W | Signed PCM sample |
| out_valid | output | 1 | A new code is present on out_code |
| out_code | output | CODE_W | Signed quantized code |
| ramp_busy | output | 1 | The coefficient walk is in progress |

## Verification
Assertions run on every cycle. They check that the step index moves by at most one and stays within 0..N, that busy only rises on an accepted sample, that states and the output code hold while no sample arrives, and that out_valid follows in_valid by one cycle. Other behaviour shows only in the bench scenarios: the exact code sequence produced by the interpolated coefficients, the hysteresis decisions, the turn-around of a walk part way through, saturation under sustained full-scale input, and arrival at the exact loud and quiet sets. The bench compares each of these against a behavioural model on every clock.

// File: rtl/adm_pkg.sv
// Shared constants and coefficient types for the adaptive modulator.
// Assumes coefficients are signed Q1.14 values held in 16 bits.
// Coefficient order within a set: gains 0..4, feedback weights 5..9, resonators 10..13.
package adm_pkg;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int ORDER     = 5;
    localparam int NCOEF     = 3 * ORDER - 1;
    localparam int G_BASE    = 0;
    localparam int A_BASE    = ORDER;
    localparam int B_BASE    = 2 * ORDER;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef coef_t coef_set_t [NCOEF];

    // Quiet set: stronger in-band shaping.
    localparam coef_set_t DEF_SET_A = '{
        16'sd8192, 16'sd8192, 16'sd8192, 16'sd8192, 16'sd8192,
        16'sd16384, 16'sd12000, 16'sd8000, 16'sd4000, 16'sd2000,
        16'sd400, 16'sd0, 16'sd300, 16'sd0};
    // Loud set: stable up to full scale.
    localparam coef_set_t DEF_SET_B = '{
        16'sd4096, 16'sd4096, 16'sd4096, 16'sd4096, 16'sd4096,
        16'sd16384, 16'sd16384, 16'sd12000, 16'sd8000, 16'sd4000,
        16'sd100, 16'sd0, 16'sd80, 16'sd0};
endpackage

// File: rtl/adm_integrator.sv
// One saturating integrator of the loop. Each accepted sample adds the
// gain-scaled error (input minus weighted feedback) and subtracts the
// resonator term from the next stage. All operands are old values.
// Assumes the caller ties b_i and nxt_i to zero for the last stage.
module adm_integrator
    import adm_pkg::*;
#(
    parameter int DW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] v_i,
    input  coef_t                g_i,
    input  coef_t                a_i,
    input  coef_t                b_i,
    input  logic signed [DW-1:0] nxt_i,
    output logic signed [DW-1:0] st_o
);
    localparam int PW = DW + 2 * COEF_W + 2;
    localparam logic signed [PW-1:0] SMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] SMIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] fb, err, gterm, rterm, sum;
    logic signed [DW-1:0] st_q, st_d;

    // Next-state arithmetic with clamping to the state range.
    always_comb begin
        fb    = (PW'(a_i) * PW'(v_i)) >>> COEF_FRAC;
        err   = PW'(in_i) - fb;
        gterm = (PW'(g_i) * err) >>> COEF_FRAC;
        rterm = (PW'(b_i) * PW'(nxt_i)) >>> COEF_FRAC;
        sum   = PW'(st_q) + gterm - rterm;
        if (sum > SMAX)      st_d = SMAX[DW-1:0];
        else if (sum < SMIN) st_d = SMIN[DW-1:0];
        else                 st_d = sum[DW-1:0];
    end

    // State register, advanced only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)  st_q <= '0;
        else if (en) st_q <= st_d;
    end

    assign st_o = st_q;

    assert_state_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q));
endmodule

// File: rtl/adm_coef_ramp.sv
// Chooses the preferred coefficient set from sample magnitude with
// hysteresis, and walks a step index toward that set's end, one step
// every STEP_EVERY accepted samples. Emits the interpolated coefficients.
// Assumes TH_LO <= TH_HI and that both fit in DW bits of magnitude.
module adm_coef_ramp
    import adm_pkg::*;
#(
    parameter int        DW         = 20,
    parameter int        RAMP_LOG2  = 3,
    parameter int        STEP_EVERY = 4,
    parameter int        TH_HI      = 367001,
    parameter int        TH_LO      = 209715,
    parameter coef_set_t SET_A      = DEF_SET_A,
    parameter coef_set_t SET_B      = DEF_SET_B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_data,
    output coef_t                coef_o [NCOEF],
    output logic                 busy
);
    localparam int NSTEP = 1 << RAMP_LOG2;
    localparam int KW    = RAMP_LOG2 + 1;
    localparam int CNTW  = (STEP_EVERY > 1) ? $clog2(STEP_EVERY) : 1;
    localparam int MW    = COEF_W + KW + 2;
    localparam logic [KW-1:0]   K_TOP   = KW'(NSTEP);
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(STEP_EVERY - 1);

    logic [KW-1:0]        k_q, dest;
    logic [CNTW-1:0]      cnt_q;
    logic                 tgt_q, tgt_d;
    logic signed [DW:0]   ext;
    logic [DW:0]          mag;

    // Magnitude and hysteresis decision for the current sample.
    always_comb begin
        ext   = {smp_data[DW-1], smp_data};
        mag   = ext[DW] ? unsigned'(-ext) : unsigned'(ext);
        tgt_d = tgt_q;
        if (smp_valid) begin
            if (mag > (DW+1)'(TH_HI))      tgt_d = 1'b1;
            else if (mag < (DW+1)'(TH_LO)) tgt_d = 1'b0;
        end
        dest = tgt_d ? K_TOP : '0;
    end

    // Preference, sample counter and step index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= 1'b0;
            k_q   <= '0;
            cnt_q <= '0;
        end else if (smp_valid) begin
            tgt_q <= tgt_d;
            if (k_q == dest) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_TOP) begin
                cnt_q <= '0;
                k_q   <= tgt_d ? k_q + 1'b1 : k_q - 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = (k_q != (tgt_q ? K_TOP : '0));

    // Linear interpolation of each coefficient between the two sets.
    for (genvar i = 0; i < NCOEF; i++) begin : g_interp
        logic signed [MW-1:0] span, scaled;
        always_comb begin
            span      = MW'(SET_B[i]) - MW'(SET_A[i]);
            scaled    = (span * $signed({{(MW-KW){1'b0}}, k_q})) >>> RAMP_LOG2;
            coef_o[i] = COEF_W'(MW'(SET_A[i]) + scaled);
        end
    end

    assert_step_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (k_q == $past(k_q)) || (k_q == $past(k_q) + 1'b1) || (k_q == $past(k_q) - 1'b1));
    assert_index_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        k_q <= K_TOP);
    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(smp_valid));
    assert_idle_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(k_q));
endmodule

// File: rtl/adaptive_dsm.sv
// Fifth-order delta-sigma modulator whose loop coefficients are walked
// between a quiet and a loud set. The code is the top CODE_W bits of the
// last integrator. It is registered one cycle after an accepted sample.
// Assumes CODE_W < DATA_W and upstream holds in_valid low between samples.
module adaptive_dsm
    import adm_pkg::*;
#(
    parameter int        DATA_W     = 20,
    parameter int        CODE_W     = 5,
    parameter int        RAMP_LOG2  = 3,
    parameter int        STEP_EVERY = 4,
    parameter int        TH_HI      = 367001,
    parameter int        TH_LO      = 209715,
    parameter coef_set_t SET_A      = DEF_SET_A,
    parameter coef_set_t SET_B      = DEF_SET_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code,
    output logic              ramp_busy
);
    localparam int QSH = DATA_W - CODE_W;

    coef_t                    coef [NCOEF];
    logic signed [DATA_W-1:0] st [ORDER];
    logic signed [DATA_W-1:0] fbv;
    logic [CODE_W-1:0]        q;
    logic [CODE_W-1:0]        code_q;
    logic                     vld_q;

    adm_coef_ramp #(
        .DW(DATA_W), .RAMP_LOG2(RAMP_LOG2), .STEP_EVERY(STEP_EVERY),
        .TH_HI(TH_HI), .TH_LO(TH_LO), .SET_A(SET_A), .SET_B(SET_B)
    ) u_ramp (
        .clk(clk), .rst_n(rst_n), .smp_valid(in_valid),
        .smp_data($signed(in_data)), .coef_o(coef), .busy(ramp_busy)
    );

    // Quantizer: keep the top bits of the last state, rebuild feedback level.
    always_comb begin
        q   = st[ORDER-1][DATA_W-1 -: CODE_W];
        fbv = $signed({q, {QSH{1'b0}}});
    end

    for (genvar j = 0; j < ORDER; j++) begin : g_stage
        logic signed [DATA_W-1:0] u_in, nxt;
        coef_t                    b_c;
        if (j == 0) begin : g_first
            assign u_in = $signed(in_data);
        end else begin : g_chain
            assign u_in = st[j-1];
        end
        if (j < ORDER - 1) begin : g_res
            assign nxt = st[j+1];
            assign b_c = coef[B_BASE + j];
        end else begin : g_last
            assign nxt = '0;
            assign b_c = '0;
        end
        adm_integrator #(.DW(DATA_W)) u_int (
            .clk(clk), .rst_n(rst_n), .en(in_valid), .in_i(u_in), .v_i(fbv),
            .g_i(coef[G_BASE + j]), .a_i(coef[A_BASE + j]), .b_i(b_c),
            .nxt_i(nxt), .st_o(st[j])
        );
    end

    // Output code register and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) code_q <= q;
        end
    end

    assign out_code  = code_q;
    assign out_valid = vld_q;

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));
    assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code));
endmodule

// File: tb/adaptive_dsm_tb.sv
// Self-checking bench: a behavioural integer model advanced per sample and
// compared with every output on every clock.
module adaptive_dsm_tb;
    import adm_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 20, QW = 5, RL = 3, M = 4;
    localparam int TH_HI = 367001, TH_LO = 209715;
    localparam int NST = 1 << RL;
    localparam int QSH = DW - QW;
    localparam longint SMAX = (longint'(1) <<< (DW-1)) - 1;
    localparam longint SMIN = -(longint'(1) <<< (DW-1));

    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [DW-1:0] in_data = '0;
    logic out_valid, ramp_busy;
    logic [QW-1:0] out_code;

    int errors = 0, checks = 0;
    string tag = "R1";

    // model state
    longint s [ORDER];
    int k, cnt, m_code, m_vld;
    bit tgt, m_busy;

    adaptive_dsm #(.DATA_W(DW), .CODE_W(QW), .RAMP_LOG2(RL), .STEP_EVERY(M),
                   .TH_HI(TH_HI), .TH_LO(TH_LO)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_code(out_code), .ramp_busy(ramp_busy));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint cf(int i);
        longint a = longint'(DEF_SET_A[i]);
        longint b = longint'(DEF_SET_B[i]);
        return a + (((b - a) * k) >>> RL);
    endfunction

    function automatic longint clampv(longint x);
        if (x > SMAX) return SMAX;
        if (x < SMIN) return SMIN;
        return x;
    endfunction

    task automatic model_reset();
        foreach (s[i]) s[i] = 0;
        k = 0; cnt = 0; tgt = 0; m_code = 0; m_vld = 0; m_busy = 0;
    endtask

    // One clock of the model, from the inputs of this cycle (R2..R9).
    task automatic model_step(bit v, longint x);
        longint ns [ORDER];
        longint q, fbv, u, mag;
        bit tn;
        int dest;
        m_vld = v;
        if (v) begin
            q   = s[ORDER-1] >>> QSH;
            fbv = q <<< QSH;
            for (int j = 0; j < ORDER; j++) begin
                longint fb, gt, rt;
                u  = (j == 0) ? x : s[j-1];
                fb = (cf(A_BASE + j) * fbv) >>> COEF_FRAC;
                gt = (cf(G_BASE + j) * (u - fb)) >>> COEF_FRAC;
                rt = (j < ORDER-1) ? ((cf(B_BASE + j) * s[j+1]) >>> COEF_FRAC) : 0;
                ns[j] = clampv(s[j] + gt - rt);
            end
            foreach (s[j]) s[j] = ns[j];
            m_code = int'(q) & ((1 << QW) - 1);
            mag = (x < 0) ? -x : x;
            tn = tgt;
            if (mag > TH_HI) tn = 1;
            else if (mag < TH_LO) tn = 0;
            dest = tn ? NST : 0;
            if (k == dest) cnt = 0;
            else if (cnt == M - 1) begin cnt = 0; k = tn ? k + 1 : k - 1; end
            else cnt++;
            tgt = tn;
        end
        m_busy = (k != (tgt ? NST : 0));
    endtask

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick(bit v, longint x);
        @(negedge clk);
        in_valid = v;
        in_data  = DW'(x);
        model_step(v, x);
        @(posedge clk);
        #1;
        check("out_valid", int'(out_valid), m_vld);
        check("out_code", int'(out_code), m_code);
        check("ramp_busy", int'(ramp_busy), int'(m_busy));
    endtask

    function automatic longint small_x(int i);
        return longint'(((i * 37) % 200) - 100) * 1500;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        // R1: reset values at the ports
        tag = "R1";
        check("out_valid", int'(out_valid), 0);
        check("out_code", int'(out_code), 0);
        check("ramp_busy", int'(ramp_busy), 0);
        @(negedge clk); rst_n = 1;

        // R2 and R8: small inputs on the quiet set, with idle gaps
        tag = "R2";
        for (int i = 0; i < 60; i++) begin
            if (i % 3 == 2) begin tag = "R8"; tick(0, 0); tag = "R2"; end
            tick(1, small_x(i));
        end

        // R4 and R5: loud input starts the walk, mid-band holds the preference
        tag = "R5";
        for (int i = 0; i < 10; i++) tick(1, (i % 2) ? 471859 : -471859);
        tag = "R4";
        for (int i = 0; i < 8; i++) tick(1, (i % 2) ? 300000 : -300000);

        // R6: quiet input part way through turns the walk around
        tag = "R6";
        for (int i = 0; i < 6; i++) tick(1, small_x(i));
        // R9 and R7: loud again until the loud set is reached exactly
        tag = "R9";
        for (int i = 0; i < 50; i++) tick(1, (i % 4 < 2) ? 471859 : -471859);
        tag = "R7";
        check("busy at loud end", int'(ramp_busy), 0);

        // R3: sustained full-scale input drives states into the clamp
        tag = "R3";
        for (int i = 0; i < 40; i++) tick(1, SMAX);
        for (int i = 0; i < 40; i++) tick(1, SMIN);

        // R7 and R9: back to the quiet set
        tag = "R7";
        for (int i = 0; i < 60; i++) tick(1, small_x(i));
        check("busy at quiet end", int'(ramp_busy), 0);

        // R8: idle cycles change nothing
        tag = "R8";
        for (int i = 0; i < 10; i++) tick(0, 12345);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule